// File: doc/BRIEF.md
# Serial-Loaded Synthesizer Control Register

This block holds the eight-bit control byte of a frequency synthesizer and applies it to the synthesizer's output pins. Software writes the byte over a three-wire serial port made of a data line, a shift clock and an active-low frame enable. The byte takes effect only when a complete frame of exactly eight shift clocks has been received. A frame of any other length is thrown away, and the stored setting stays as it was.

The stored bits do not go to any readback path. They shape the pins. The raw detector signals come in, and the block drives them out after four kinds of processing. It can invert the single-ended phase error and swap the reference-side and VCO-side pulse pair. It can choose between the single-ended output and the pulse pair, and it tri-states the output that is not chosen. It can gate the lock flag. It can gate the two divided-frequency strobes. Three bits form a divider select, which goes out to a separate reference divider.

All serial inputs are synchronised into the system clock domain and handled through edge detection. The block therefore runs on a single clock.

Top module: `synthCtlReg`

## Requirements
- R1: After reset the register holds 0x10. At the pins this means the following: `refDivSel` is 3'b100, `pdOutEn` is 0, `lockOut` is 0, both strobe outputs are 0, and the pulse pair passes straight through.
- R2: While `serEnN` is low, each rising edge of `serClk` shifts `serData` into the frame, most significant bit first. When `serEnN` rises after exactly 8 shift clocks, the received byte replaces the register.
- R3: When `serEnN` rises after fewer or more than 8 shift clocks, the register is left unchanged.
- R4: When bit 7 is 1, `pdOut` is the inverse of `pdSingleIn`. In the same case, `pdRefOut` carries `pdVcoIn` and `pdVcoOut` carries `pdRefIn`. When bit 7 is 0, no signal is inverted or swapped.
- R5: When bit 6 is 1, `pdOutEn` is 1 and both `pdRefOut` and `pdVcoOut` are held high. When bit 6 is 0, `pdOutEn` is 0, `pdOut` is 0, and the pulse pair is active.
- R6: The forcing set by bit 6 takes priority over the polarity set by bit 7. With both bits at 1, the pulse outputs stay high.
- R7: When bit 5 is 1, `lockOut` follows `lockIn`. When bit 5 is 0, `lockOut` is held low.
- R8: When bit 1 is 1, `vcoStrobeOut` follows `vcoStrobeIn`. When bit 0 is 1, `refStrobeOut` follows `refStrobeIn`. Each strobe output is held low while its bit is 0.
- R9: `refDivSel` always shows register bits 4 down to 2, with bit 4 in the most significant position.
- R10: The frame's bit count and shift contents are cleared whenever `serEnN` is high. An aborted partial frame therefore does not affect the following 8-clock frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serData | input | 1 | Serial data line |
| serClk | input | 1 | Serial shift clock |
| serEnN | input | 1 | Active-low frame enable |
| pdSingleIn | input | 1 | Raw single-ended phase error |
| pdRefIn | input | 1 | Raw reference-side detector pulse |
| pdVcoIn | input | 1 | Raw VCO-side detector pulse |
| lockIn | input | 1 | Raw lock-detect flag |
| refStrobeIn | input | 1 | Divided reference strobe |
| vcoStrobeIn | input | 1 | Divided VCO strobe |
| pdOut | output | 1 | Single-ended detector output value |
| pdOutEn | output | 1 | Tri-state enable for `pdOut` |
| pdRefOut | output | 1 | Reference-side pulse output |
| pdVcoOut | output | 1 | VCO-side pulse output |
| lockOut | output | 1 | Gated lock-detect output |
| refStrobeOut | output | 1 | Gated reference strobe |
| vcoStrobeOut | output | 1 | Gated VCO strobe |
| refDivSel | output | 3 | Reference divider select |

## Verification
The hardest case to reach is a frame boundary that follows an aborted frame. The bit count must restart cleanly, and a short or long frame must leave every pin exactly as it was. The stimulus produces this by first committing a known byte. It then sends frames of five and nine clocks whose data would change every field. It follows these with a partial frame and then a full one. After each frame the bench sweeps all 64 combinations of the raw detector inputs. A register change that slipped through would then show up on at least one pin.

// File: rtl/synthCtlPkg.sv
package synthCtlPkg;

  localparam int CTL_W = 8;
  localparam logic [CTL_W-1:0] CTL_RESET = 8'h10;

  // Field positions; the pin logic decodes these
  localparam int POL_BIT  = 7;
  localparam int SEL_BIT  = 6;
  localparam int LOCK_BIT = 5;
  localparam int DIV_HI   = 4;
  localparam int DIV_LO   = 2;
  localparam int DIV_W    = DIV_HI - DIV_LO + 1;
  localparam int VCO_BIT  = 1;
  localparam int REF_BIT  = 0;

  // Strobes from serial control to the register datapath
  typedef struct packed {
    logic shift;
    logic commit;
    logic clear;
  } serStrobe_t;

endpackage

// File: rtl/synthCtlSerialCtrl.sv
module synthCtlSerialCtrl
  import synthCtlPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serEnN,
  input  logic       serData,
  output serStrobe_t strb,
  output logic       dataBit
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] clkSync, enSync, datSync;
  logic clkPrev, enPrev;
  logic clkNow, enNow;
  logic [CNT_W-1:0] bitCount;

  // Synchroniser chains, one per serial line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync <= '0;
      enSync  <= '1;
      datSync <= '0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], serClk};
      enSync  <= {enSync[SYNC_STAGES-2:0], serEnN};
      datSync <= {datSync[SYNC_STAGES-2:0], serData};
    end
  end

  assign clkNow  = clkSync[SYNC_STAGES-1];
  assign enNow   = enSync[SYNC_STAGES-1];
  assign dataBit = datSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      enPrev  <= 1'b1;
    end else begin
      clkPrev <= clkNow;
      enPrev  <= enNow;
    end
  end

  assign strb.shift  = clkNow & ~clkPrev & ~enNow;
  assign strb.clear  = enNow;
  assign strb.commit = enNow & ~enPrev & (bitCount == CNT_FULL);

  // Counter saturates one past a full frame so long frames never wrap
  always_ff @(posedge clk) begin
    if (!rstN || enNow) begin
      bitCount <= '0;
    end else if (strb.shift && bitCount != CNT_SAT) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  // R10: an idle enable leaves no residual count
  a_r10_count_cleared: assert property (@(posedge clk) disable iff (!rstN)
    enNow |=> (bitCount == '0));

  // R2: shifting and committing never coincide
  a_r2_no_shift_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !strb.shift);

endmodule

// File: rtl/synthCtlRegFile.sv
module synthCtlRegFile
  import synthCtlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  serStrobe_t       strb,
  input  logic             dataBit,
  output logic [CTL_W-1:0] ctlReg
);

  logic [CTL_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      shiftReg <= '0;
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[CTL_W-2:0], dataBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= CTL_RESET;
    end else if (strb.commit) begin
      ctlReg <= shiftReg;
    end
  end

  // R2 and R3: the setting moves only on a commit strobe
  a_r3_change_needs_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctlReg) |-> $past(strb.commit));

endmodule

// File: rtl/synthCtlPinDrive.sv
module synthCtlPinDrive
  import synthCtlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CTL_W-1:0] ctlReg,
  input  logic             pdSingleIn,
  input  logic             pdRefIn,
  input  logic             pdVcoIn,
  input  logic             lockIn,
  input  logic             refStrobeIn,
  input  logic             vcoStrobeIn,
  output logic             pdOut,
  output logic             pdOutEn,
  output logic             pdRefOut,
  output logic             pdVcoOut,
  output logic             lockOut,
  output logic             refStrobeOut,
  output logic             vcoStrobeOut,
  output logic [DIV_W-1:0] refDivSel
);

  logic polInv, selSingle;
  logic singlePol, refPol, vcoPol;
  logic [1:0] strobeIn, strobeOut;

  assign polInv    = ctlReg[POL_BIT];
  assign selSingle = ctlReg[SEL_BIT];

  // Polarity stage first
  always_comb begin
    singlePol = pdSingleIn ^ polInv;
    refPol    = polInv ? pdVcoIn : pdRefIn;
    vcoPol    = polInv ? pdRefIn : pdVcoIn;
  end

  // Then forcing by detector selection
  always_comb begin
    pdOutEn  = selSingle;
    pdOut    = selSingle & singlePol;
    pdRefOut = selSingle | refPol;
    pdVcoOut = selSingle | vcoPol;
  end

  assign lockOut = ctlReg[LOCK_BIT] & lockIn;

  // Strobe gates: index 0 reference, index 1 VCO
  assign strobeIn = {vcoStrobeIn, refStrobeIn};
  for (genvar g = 0; g < 2; g++) begin : gStrobe
    localparam int EN_BIT = (g == 0) ? REF_BIT : VCO_BIT;
    assign strobeOut[g] = ctlReg[EN_BIT] & strobeIn[g];
  end
  assign refStrobeOut = strobeOut[0];
  assign vcoStrobeOut = strobeOut[1];

  assign refDivSel = ctlReg[DIV_HI:DIV_LO];

  a_r5_single_forces_pair: assert property (@(posedge clk) disable iff (!rstN)
    selSingle |-> (pdOutEn && pdRefOut && pdVcoOut));

  a_r5_pair_tristates_single: assert property (@(posedge clk) disable iff (!rstN)
    !selSingle |-> (!pdOutEn && !pdOut));

  a_r7_lock_gated: assert property (@(posedge clk) disable iff (!rstN)
    !ctlReg[LOCK_BIT] |-> !lockOut);

  a_r8_strobes_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlReg[VCO_BIT] |-> !vcoStrobeOut) and (!ctlReg[REF_BIT] |-> !refStrobeOut));

endmodule

// File: rtl/synthCtlReg.sv
module synthCtlReg
  import synthCtlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serData,
  input  logic       serClk,
  input  logic       serEnN,
  input  logic       pdSingleIn,
  input  logic       pdRefIn,
  input  logic       pdVcoIn,
  input  logic       lockIn,
  input  logic       refStrobeIn,
  input  logic       vcoStrobeIn,
  output logic       pdOut,
  output logic       pdOutEn,
  output logic       pdRefOut,
  output logic       pdVcoOut,
  output logic       lockOut,
  output logic       refStrobeOut,
  output logic       vcoStrobeOut,
  output logic [2:0] refDivSel
);

  serStrobe_t strb;
  logic dataBit;
  logic [CTL_W-1:0] ctlReg;

  synthCtlSerialCtrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BITS (CTL_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serEnN (serEnN),
    .serData(serData),
    .strb   (strb),
    .dataBit(dataBit)
  );

  synthCtlRegFile u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dataBit(dataBit),
    .ctlReg (ctlReg)
  );

  synthCtlPinDrive u_pins (
    .clk         (clk),
    .rstN        (rstN),
    .ctlReg      (ctlReg),
    .pdSingleIn  (pdSingleIn),
    .pdRefIn     (pdRefIn),
    .pdVcoIn     (pdVcoIn),
    .lockIn      (lockIn),
    .refStrobeIn (refStrobeIn),
    .vcoStrobeIn (vcoStrobeIn),
    .pdOut       (pdOut),
    .pdOutEn     (pdOutEn),
    .pdRefOut    (pdRefOut),
    .pdVcoOut    (pdVcoOut),
    .lockOut     (lockOut),
    .refStrobeOut(refStrobeOut),
    .vcoStrobeOut(vcoStrobeOut),
    .refDivSel   (refDivSel)
  );

endmodule

// File: tb/synthCtlReg_bench.sv
module synthCtlReg_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData = 1'b0, serClk = 1'b0, serEnN = 1'b1;
  logic pdSingleIn = 0, pdRefIn = 0, pdVcoIn = 0, lockIn = 0, refStrobeIn = 0, vcoStrobeIn = 0;
  logic pdOut, pdOutEn, pdRefOut, pdVcoOut, lockOut, refStrobeOut, vcoStrobeOut;
  logic [2:0] refDivSel;

  always #10 clk = ~clk;

  synthCtlReg u_synthCtlReg (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk), .serEnN(serEnN),
    .pdSingleIn(pdSingleIn), .pdRefIn(pdRefIn), .pdVcoIn(pdVcoIn), .lockIn(lockIn),
    .refStrobeIn(refStrobeIn), .vcoStrobeIn(vcoStrobeIn),
    .pdOut(pdOut), .pdOutEn(pdOutEn), .pdRefOut(pdRefOut), .pdVcoOut(pdVcoOut),
    .lockOut(lockOut), .refStrobeOut(refStrobeOut), .vcoStrobeOut(vcoStrobeOut),
    .refDivSel(refDivSel)
  );

  typedef struct {
    logic [7:0] expReg;
    string      ctx;
  } expItem_t;

  expItem_t expQ[$];
  int vectors = 0;
  int miscompares = 0;
  bit monBusy = 0;
  bit finished = 0;
  logic [7:0] model = 8'h10;

  task automatic checkVal(string req, string ctx, string name, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, ctx, name, act, exp);
    end
  endtask

  // Monitor: pops expected settings and sweeps the raw inputs
  initial begin
    forever begin
      wait (expQ.size() > 0);
      monBusy = 1;
      begin
        expItem_t it;
        logic pol, sel, eSingle, eRef, eVco;
        it = expQ.pop_front();
        pol = it.expReg[7];
        sel = it.expReg[6];
        for (int v = 0; v < 64; v++) begin
          @(negedge clk);
          {pdSingleIn, pdRefIn, pdVcoIn, lockIn, refStrobeIn, vcoStrobeIn} = v[5:0];
          #1;
          eSingle = sel & (pdSingleIn ^ pol);
          eRef = sel | (pol ? pdVcoIn : pdRefIn);
          eVco = sel | (pol ? pdRefIn : pdVcoIn);
          checkVal("R4", it.ctx, "pdOut", {7'd0, pdOut}, {7'd0, eSingle});
          checkVal("R5", it.ctx, "pdOutEn", {7'd0, pdOutEn}, {7'd0, sel});
          checkVal(sel && pol ? "R6" : "R4", it.ctx, "pdRefOut", {7'd0, pdRefOut}, {7'd0, eRef});
          checkVal(sel && pol ? "R6" : "R5", it.ctx, "pdVcoOut", {7'd0, pdVcoOut}, {7'd0, eVco});
          checkVal("R7", it.ctx, "lockOut", {7'd0, lockOut}, {7'd0, it.expReg[5] & lockIn});
          checkVal("R8", it.ctx, "vcoStrobeOut", {7'd0, vcoStrobeOut}, {7'd0, it.expReg[1] & vcoStrobeIn});
          checkVal("R8", it.ctx, "refStrobeOut", {7'd0, refStrobeOut}, {7'd0, it.expReg[0] & refStrobeIn});
          checkVal("R9", it.ctx, "refDivSel", {5'd0, refDivSel}, {5'd0, it.expReg[4:2]});
        end
      end
      monBusy = 0;
    end
  end

  task automatic pushAndWait(string ctx);
    expItem_t it;
    it.expReg = model;
    it.ctx = ctx;
    expQ.push_back(it);
    wait (expQ.size() == 0 && !monBusy);
  endtask

  task automatic serialStep;
    repeat (3) @(negedge clk);
  endtask

  // Driver: sends one frame of nClk shift clocks; only 8 updates the model
  task automatic sendFrame(logic [7:0] val, int nClk, string ctx);
    @(negedge clk);
    serEnN = 1'b0;
    serialStep();
    for (int i = 0; i < nClk; i++) begin
      serData = (i < 8) ? val[7 - i] : 1'b1;
      serialStep();
      serClk = 1'b1;
      serialStep();
      serClk = 1'b0;
    end
    serialStep();
    serEnN = 1'b1;
    repeat (8) @(negedge clk);
    if (nClk == 8) model = val;
    pushAndWait(ctx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    pushAndWait("R1 reset value");
    sendFrame(8'h63, 8, "R2 single-ended, lock, strobes");
    sendFrame(8'hC0, 8, "R6 polarity with single-ended");
    sendFrame(8'h83, 8, "R4 polarity with pulse pair");
    sendFrame(8'h3E, 8, "R2 pair, lock, div 111");
    sendFrame(8'hC1, 5, "R3 short frame discarded");
    sendFrame(8'hC1, 9, "R3 long frame discarded");
    sendFrame(8'h55, 3, "R10 partial frame");
    sendFrame(8'h09, 8, "R10 full frame after partial");
    sendFrame(8'hA6, 8, "R2 mixed byte");
    sendFrame(8'h00, 8, "R2 all clear");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule